// File: doc/BRIEF.md
# Programmable Parallel Port Adapter

This block gives a processor three 8-bit parallel ports, called A, B and C, behind a four-location register window. Port C is split into a high and a low nibble that are steered separately. Each port has a registered output bus, an unregistered input bus and output-enable lines. Port C has one enable per bit, so an external pad ring can build bidirectional pins from these signals. The processor uses active-low select, read and write strobes, a 2-bit location address, and separate write and read data buses. Every state change happens on the rising clock edge.

A single control location does two jobs. When the top bit of the written byte is 1, the write replaces the whole mode and direction setting. When the top bit is 0, the write sets or clears one port C bit and leaves all other state alone. The group mode codes are stored and read back, but every port behaves as plain static I/O whatever mode code is held. A read of a port set to output returns its output register. A read of a port set to input returns its live pins.

Top module: `par_port_adapter`

## Requirements
- R1: After reset the control location reads 8'h9B, every output-enable is low, and the A, B and C output buses are zero.
- R2: A write to address 2'b00, 2'b01 or 2'b10 loads the port A, port B or port C output register, and the value appears on that port's output bus. A read of an output-direction port returns its output register.
- R3: A read of a port whose direction is input returns the live input pins, with no register in the path.
- R4: A control write with data bit 7 = 1 stores bits 6:0, reads back with bit 7 forced to 1, and clears the A, B and C output registers to zero.
- R5: Direction bits in the control byte are 1 for input and 0 for output. Bit 4 drives the port A enable, bit 1 the port B enable, bit 3 the enables of C[7:4] and bit 0 the enables of C[3:0]. An enable is high when its port is an output.
- R6: A control write with data bit 7 = 0 writes data bit 0 into the port C output bit selected by data bits 3:1. Data bits 6:4 are ignored. No other port C bit, no other port and no direction changes.
- R7: A write is performed once per low pulse of the write strobe. Data presented while the strobe stays low after the first clock edge is not taken.
- R8: Nothing is written unless chip select is low. The read bus is zero unless both chip select and the read strobe are low.
- R9: Group A mode codes 01 and 1X, and group B mode code 1, are stored and read back unchanged. The ports still act as static I/O.
- R10: A read of port C takes each nibble from the output register or the pins according to that nibble's own direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Location select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor |
| a_in | input | 8 | Port A input pins |
| b_in | input | 8 | Port B input pins |
| c_in | input | 8 | Port C input pins |
| a_out | output | 8 | Port A output register |
| b_out | output | 8 | Port B output register |
| c_out | output | 8 | Port C output register |
| a_oe | output | 1 | Port A output enable |
| b_oe | output | 1 | Port B output enable |
| c_oe | output | 8 | Port C per-bit output enables |

## Verification
The hardest case to reach is a write strobe held low across several clock edges while the data bus changes under it. A write that took effect every cycle would be invisible in ordinary one-cycle pulses. The bench keeps write low for three edges and swaps the data after the first one. It then checks that the port still shows the first value. Mixed port C directions are reached by programming each nibble opposite to the other and driving distinct pin values, so a wrong nibble source shows up in the read value.

// File: rtl/par_port_adapter.sv
module par_port_adapter (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] a_in,
  input  logic [7:0] b_in,
  input  logic [7:0] c_in,
  output logic [7:0] a_out,
  output logic [7:0] b_out,
  output logic [7:0] c_out,
  output logic       a_oe,
  output logic       b_oe,
  output logic [7:0] c_oe
);
  localparam logic [6:0] CTRL_INIT = 7'h1B;

  logic [6:0] ctrl;
  logic       wr_n_q;
  logic       wr_go;
  logic       rd_go;
  logic [7:0] c_rd;

  assign wr_go = !cs_n && !wr_n && wr_n_q;
  assign rd_go = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (rst) wr_n_q <= 1'b1;
    else     wr_n_q <= wr_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= CTRL_INIT;
      a_out <= '0;
      b_out <= '0;
      c_out <= '0;
    end else if (wr_go) begin
      case (addr)
        2'd0: a_out <= wdata;
        2'd1: b_out <= wdata;
        2'd2: c_out <= wdata;
        default: begin
          if (wdata[7]) begin
            ctrl  <= wdata[6:0];
            a_out <= '0;
            b_out <= '0;
            c_out <= '0;
          end else begin
            c_out[wdata[3:1]] <= wdata[0];
          end
        end
      endcase
    end
  end

  assign a_oe = !ctrl[4];
  assign b_oe = !ctrl[1];
  assign c_oe = {{4{!ctrl[3]}}, {4{!ctrl[0]}}};

  assign c_rd = {ctrl[3] ? c_in[7:4] : c_out[7:4],
                 ctrl[0] ? c_in[3:0] : c_out[3:0]};

  always_comb begin
    rdata = '0;
    if (rd_go) begin
      case (addr)
        2'd0:    rdata = ctrl[4] ? a_in : a_out;
        2'd1:    rdata = ctrl[1] ? b_in : b_out;
        2'd2:    rdata = c_rd;
        default: rdata = {1'b1, ctrl};
      endcase
    end
  end
endmodule

// File: rtl/ppa_checker.sv
module ppa_checker (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] a_in,
  input logic [7:0] a_out,
  input logic [7:0] b_out,
  input logic [7:0] c_out,
  input logic       a_oe,
  input logic       b_oe,
  input logic [7:0] c_oe
);
  p_out_read_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == 2'd0 && a_oe) |-> rdata == a_out);

  p_in_read_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == 2'd0 && !a_oe) |-> rdata == a_in);

  p_ctrl_top_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == 2'd3) |-> rdata[7]);

  p_mode_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && $past(wr_n) && addr == 2'd3 && wdata[7])
      |=> (a_out == 8'h00 && b_out == 8'h00 && c_out == 8'h00));

  p_nibble_oe_r5: assert property (@(posedge clk) disable iff (rst)
    (c_oe[7:4] == 4'h0 || c_oe[7:4] == 4'hF) && (c_oe[3:0] == 4'h0 || c_oe[3:0] == 4'hF));

  p_bsr_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && $past(wr_n) && addr == 2'd3 && !wdata[7])
      |=> ($stable({a_oe, b_oe, c_oe}) && $stable(a_out) && $stable(b_out)));

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> rdata == 8'h00);
endmodule

bind par_port_adapter ppa_checker chk_i (.*);

// File: tb/par_port_adapter_tb.sv
module par_port_adapter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] a_in = '0, b_in = '0, c_in = '0;
  logic [7:0] rdata, a_out, b_out, c_out, c_oe;
  logic a_oe, b_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  par_port_adapter dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .a_out(a_out), .b_out(b_out), .c_out(c_out),
    .a_oe(a_oe), .b_oe(b_oe), .c_oe(c_oe));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd3, d); check("R1 ctrl", d, 8'h9B);
    check("R1 oe", {a_oe, b_oe, 6'b0}, 8'h00);
    check("R1 c_oe", c_oe, 8'h00);
    check("R1 outs", a_out | b_out | c_out, 8'h00);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    wr(2'd3, 8'h80);
    check("R5 oe", {a_oe, b_oe, 6'b0}, 8'hC0);
    check("R5 c_oe", c_oe, 8'hFF);
    a_in = 8'hEE; b_in = 8'hEE; c_in = 8'hEE;
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3); wr(2'd2, 8'h96);
    check("R2 a_out", a_out, 8'h5A);
    check("R2 b_out", b_out, 8'hC3);
    check("R2 c_out", c_out, 8'h96);
    rd(2'd0, d); check("R2 read A", d, 8'h5A);
    rd(2'd1, d); check("R2 read B", d, 8'hC3);
    rd(2'd2, d); check("R2 read C", d, 8'h96);
  endtask

  task automatic t_inputs();
    logic [7:0] d;
    wr(2'd3, 8'h9B);
    a_in = 8'h11; b_in = 8'h44;
    rd(2'd0, d); check("R3 read A", d, 8'h11);
    rd(2'd1, d); check("R3 read B", d, 8'h44);
    a_in = 8'h22;
    rd(2'd0, d); check("R3 read A live", d, 8'h22);
  endtask

  task automatic t_mixed_c();
    logic [7:0] d;
    wr(2'd3, 8'h81);
    check("R5 c_oe low in", c_oe, 8'hF0);
    wr(2'd2, 8'hAB); c_in = 8'h35;
    rd(2'd2, d); check("R10 C low in", d, 8'hA5);
    wr(2'd3, 8'h88);
    check("R5 c_oe high in", c_oe, 8'h0F);
    wr(2'd2, 8'hAB);
    rd(2'd2, d); check("R10 C high in", d, 8'h3B);
  endtask

  task automatic t_mode_clear();
    logic [7:0] d;
    wr(2'd3, 8'h80);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    wr(2'd3, 8'h80);
    check("R4 clear", a_out | b_out | c_out, 8'h00);
    wr(2'd3, 8'h15);
    wr(2'd3, 8'h95);
    rd(2'd3, d); check("R4 readback", d, 8'h95);
    check("R5 mixed oe", {a_oe, b_oe, 6'b0}, 8'h40);
  endtask

  task automatic t_bsr();
    logic [7:0] d;
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h66);
    wr(2'd3, 8'h7B); check("R6 set bit5", c_out, 8'h20);
    wr(2'd3, 8'h01); check("R6 set bit0", c_out, 8'h21);
    wr(2'd3, 8'h0A); check("R6 clr bit5", c_out, 8'h01);
    wr(2'd3, 8'h4F); check("R6 set bit7", c_out, 8'h81);
    rd(2'd3, d); check("R6 ctrl kept", d, 8'h80);
    check("R6 A kept", a_out, 8'h66);
    check("R6 c_oe kept", c_oe, 8'hFF);
  endtask

  task automatic t_single_write();
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = 2'd0; wdata = 8'h12;
    @(negedge clk);
    check("R7 first", a_out, 8'h12);
    wdata = 8'h34;
    @(negedge clk); @(negedge clk);
    check("R7 held low", a_out, 8'h12);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic t_no_cs();
    @(negedge clk);
    cs_n = 1; wr_n = 0; addr = 2'd0; wdata = 8'h77;
    @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    check("R8 no write", a_out, 8'h12);
    rd_n = 0; addr = 2'd3;
    #1 check("R8 idle bus", rdata, 8'h00);
    @(negedge clk);
    rd_n = 1;
  endtask

  task automatic t_modes();
    logic [7:0] d;
    wr(2'd3, 8'hC4);
    rd(2'd3, d); check("R9 mode2/1 read", d, 8'hC4);
    wr(2'd0, 8'h3C);
    rd(2'd0, d); check("R9 static A", d, 8'h3C);
    check("R9 a_oe", {7'b0, a_oe}, 8'h01);
    wr(2'd3, 8'hA0);
    rd(2'd3, d); check("R9 mode1 read", d, 8'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_outputs();
    t_inputs();
    t_mixed_c();
    t_mode_clear();
    t_bsr();
    wr(2'd3, 8'h80);
    t_single_write();
    t_no_cs();
    t_modes();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule